// File: doc/BRIEF.md
# Change-Filtered Shared-Memory Write Transmitter

This block sits in a replicated shared-memory node between the host write port and the ring-network transmit port. Each host write carries a longword address, 32 data bits, four byte enables and an interrupt flag. The block merges the enabled bytes into the word held in a local shadow memory. It writes the result back and decides whether the network must hear about it. With the change filter on, a write that leaves the stored word unchanged produces no message. Otherwise a message of the full longword address, the complete merged 32-bit word and the interrupt flag goes into a transmit queue.

The queue drains to a valid/ready network port, and a transmit-enable input can hold every queued message back. Three level flags are exported: queue full, queue not empty, and queue at least seven-eighths full. When the queue is full the host write is stretched with `hw_ready` low. It is never dropped. A side read port shows the shadow memory, so the filtered result can be seen.

Top module: `shmem_write_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the block empties the queue, clears every shadow word to zero and drops all three flags. After that edge `tx_valid` is low.
- R2: If `filt_en` is 1 for an accepted write and the merged word equals the stored word, no message is queued and the stored word keeps its value.
- R3: If `filt_en` is 0 for an accepted write, a message is queued even when the merged word equals the stored word.
- R4: An accepted write stores the merged word. For each byte lane i, byte i (bits 8i+7..8i) comes from `hw_data` when `hw_be[i]` is 1 and from the stored word otherwise. Any message it queues carries the full 21-bit `hw_addr`, the full merged word and `hw_irq`.
- R5: The queue hands messages out oldest first. A message leaves only in a cycle where `tx_valid` and `tx_ready` are both high. While it waits, the head stays unchanged on `tx_addr`, `tx_data` and `tx_irq`.
- R6: While `tx_enable` is 0, `tx_valid` is low and no queued message is lost, whatever `tx_ready` does.
- R7: When the queue holds FIFO_DEPTH messages, `fifo_full` is 1 and `hw_ready` is 0. A pending write waits without touching memory until a message has left, and is then accepted.
- R8: `fifo_not_empty` is 1 exactly when the queue holds at least one message. `fifo_high` is 1 exactly when it holds at least FIFO_DEPTH - FIFO_DEPTH/8 messages (896 by default).
- R9: `filt_en` is taken from each write on its own, so back-to-back writes with different settings are each filtered by their own value.
- R10: The shadow memory is indexed by the low MEM_AW bits of `hw_addr` (and of `rd_addr`), and `rd_data` shows that word without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_valid | input | 1 | Host write request |
| hw_ready | output | 1 | Host write accepted at this edge (low while queue full) |
| hw_addr | input | 21 | Longword address of the write |
| hw_data | input | 32 | Write data |
| hw_be | input | 4 | Byte enables, bit i selects bits 8i+7..8i |
| hw_irq | input | 1 | Interrupt flag to carry in the message |
| filt_en | input | 1 | Suppress messages for unchanged words |
| rd_addr | input | MEM_AW | Shadow memory read index |
| rd_data | output | 32 | Shadow word at `rd_addr` |
| tx_enable | input | 1 | Allow queued messages onto the network port |
| tx_valid | output | 1 | Head message is offered |
| tx_ready | input | 1 | Network side takes the head message |
| tx_addr | output | 21 | Head message address |
| tx_data | output | 32 | Head message data |
| tx_irq | output | 1 | Head message interrupt flag |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH messages |
| fifo_not_empty | output | 1 | Queue holds at least one message |
| fifo_high | output | 1 | Queue at least seven-eighths full |

## Verification
A wrong occupancy count shows up in the next cycle: a flag changes at the wrong threshold, or `hw_ready` stalls or releases one write off. A pointer fault shows up when the next message is popped, as the wrong address or data on the transmit port. A bad merge or compare shows up at once on `rd_data`, or as an extra or missing message. Draining the queue after each scenario confirms that the exact message sequence came out and nothing more.

// File: rtl/shwtx_pkg.sv
package shwtx_pkg;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              irq;
    } tx_msg_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'b00,
        CNT_DEC  = 2'b01,
        CNT_INC  = 2'b10,
        CNT_BOTH = 2'b11
    } cnt_op_e;

endpackage

// File: rtl/shwtx_shadow_mem.sv
module shwtx_shadow_mem
    import shwtx_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MEM_AW-1:0] cmp_addr,
    output logic [DATA_W-1:0] cmp_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << MEM_AW;

    logic [DATA_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign cmp_data = words[cmp_addr];
    assign rd_data  = words[rd_addr];
endmodule

// File: rtl/shwtx_filter.sv
module shwtx_filter
    import shwtx_pkg::*;
(
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] incoming,
    input  logic [BE_W-1:0]   be,
    input  logic              filt_en,
    output logic [DATA_W-1:0] merged,
    output logic              send
);
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign merged[8*b +: 8] = be[b] ? incoming[8*b +: 8] : stored[8*b +: 8];
    end

    logic changed;
    assign changed = (merged != stored);
    assign send    = !filt_en || changed;
endmodule

// File: rtl/shwtx_fifo.sv
module shwtx_fifo
    import shwtx_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  tx_msg_t din,
    input  logic    pop,
    output tx_msg_t dout,
    output logic    full,
    output logic    not_empty,
    output logic    high
);
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int HI_MARK = DEPTH - DEPTH / 8;

    tx_msg_t           store [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    cnt_op_e           op;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign op = cnt_op_e'({push, pop});

    always_ff @(posedge clk) begin
        if (push) begin
            store[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case (op)
                CNT_INC: cnt <= cnt + 1'b1;
                CNT_DEC: cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout      = store[rp];
    assign full      = (cnt == CNT_W'(DEPTH));
    assign not_empty = (cnt != '0);
    assign high      = (cnt >= CNT_W'(HI_MARK));
endmodule

// File: rtl/shmem_write_tx.sv
module shmem_write_tx
    import shwtx_pkg::*;
#(
    parameter int MEM_AW     = 8,
    parameter int FIFO_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_valid,
    output logic              hw_ready,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [DATA_W-1:0] hw_data,
    input  logic [BE_W-1:0]   hw_be,
    input  logic              hw_irq,
    input  logic              filt_en,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_enable,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_irq,
    output logic              fifo_full,
    output logic              fifo_not_empty,
    output logic              fifo_high
);
    logic              accept;
    logic              push;
    logic              pop;
    logic              send;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] merged;
    logic [MEM_AW-1:0] idx;
    tx_msg_t           in_msg;
    tx_msg_t           head;

    assign idx      = hw_addr[MEM_AW-1:0];
    assign hw_ready = !fifo_full;
    assign accept   = hw_valid && hw_ready;
    assign push     = accept && send;

    shwtx_shadow_mem #(.MEM_AW(MEM_AW)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .we       (accept),
        .waddr    (idx),
        .wdata    (merged),
        .cmp_addr (idx),
        .cmp_data (stored),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    shwtx_filter u_filt (
        .stored   (stored),
        .incoming (hw_data),
        .be       (hw_be),
        .filt_en  (filt_en),
        .merged   (merged),
        .send     (send)
    );

    always_comb begin
        in_msg.addr = hw_addr;
        in_msg.data = merged;
        in_msg.irq  = hw_irq;
    end

    shwtx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .din       (in_msg),
        .pop       (pop),
        .dout      (head),
        .full      (fifo_full),
        .not_empty (fifo_not_empty),
        .high      (fifo_high)
    );

    assign tx_valid = fifo_not_empty && tx_enable;
    assign pop      = tx_valid && tx_ready;
    assign tx_addr  = head.addr;
    assign tx_data  = head.data;
    assign tx_irq   = head.irq;
endmodule

// File: rtl/shmem_write_tx_chk.sv
module shmem_write_tx_chk
    import shwtx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hw_valid,
    input logic              hw_ready,
    input logic              tx_enable,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [ADDR_W-1:0] tx_addr,
    input logic [DATA_W-1:0] tx_data,
    input logic              fifo_full,
    input logic              fifo_not_empty,
    input logic              fifo_high
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (!fifo_not_empty && !fifo_full && !fifo_high && !tx_valid));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> ($stable(tx_addr) && $stable(tx_data)));

    // R5
    no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_not_empty && !(hw_valid && hw_ready)) |=> !fifo_not_empty);

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !(tx_valid && tx_ready)) |=> fifo_full);

    // R8
    flag_order_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (fifo_high && fifo_not_empty));

    // R6
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && fifo_not_empty) |=> fifo_not_empty);
endmodule

bind shmem_write_tx shmem_write_tx_chk u_chk (.*);

// File: tb/shmem_write_tx_tb.sv
module shmem_write_tx_tb;
    localparam int AW    = 21;
    localparam int DW    = 32;
    localparam int MAW   = 8;
    localparam int DEPTH = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hw_valid = 1'b0;
    logic          hw_ready;
    logic [AW-1:0] hw_addr = '0;
    logic [DW-1:0] hw_data = '0;
    logic [3:0]    hw_be = 4'hF;
    logic          hw_irq = 1'b0;
    logic          filt_en = 1'b1;
    logic [MAW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          tx_enable = 1'b1;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [AW-1:0] tx_addr;
    logic [DW-1:0] tx_data;
    logic          tx_irq;
    logic          fifo_full, fifo_not_empty, fifo_high;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shmem_write_tx #(.MEM_AW(MAW), .FIFO_DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] be, input logic irq, input logic fe);
        @(negedge clk);
        hw_addr = a; hw_data = d; hw_be = be; hw_irq = irq; filt_en = fe;
        hw_valid = 1'b1;
        while (!hw_ready) @(negedge clk);
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic irq);
        @(negedge clk);
        chk({tag, " valid"}, tx_valid, 1);
        chk({tag, " addr"}, tx_addr, a);
        chk({tag, " data"}, tx_data, d);
        chk({tag, " irq"}, tx_irq, irq);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic t_reset;
        rd_addr = 8'd3;
        @(negedge clk);
        chk("R1 not_empty", fifo_not_empty, 0);
        chk("R1 full", fifo_full, 0);
        chk("R1 high", fifo_high, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 mem zero", rd_data, 0);
        chk("R1 ready", hw_ready, 1);
    endtask

    task automatic t_change_merge;
        wr(21'h000005, 32'hA5A5_1234, 4'hF, 1'b1, 1'b1);
        rd_addr = 8'd5;
        #0;
        chk("R4 mem stored", rd_data, 32'hA5A5_1234);
        chk("R4 queued", fifo_not_empty, 1);
        // upper address bits alias lane index 5 (R10) but ride in the message
        wr(21'h100005, 32'hFFFF_FFFF, 4'b0001, 1'b0, 1'b1);
        #0;
        chk("R4 merged mem", rd_data, 32'hA5A5_12FF);
        chk("R10 alias index", rd_data, 32'hA5A5_12FF);
    endtask

    task automatic t_filter_equal;
        wr(21'h000005, 32'hA5A5_12FF, 4'hF, 1'b1, 1'b1);
        #0;
        chk("R2 mem kept", rd_data, 32'hA5A5_12FF);
        pop_chk("R4 msg1", 21'h000005, 32'hA5A5_1234, 1'b1);
        pop_chk("R4 msg2 full addr", 21'h100005, 32'hA5A5_12FF, 1'b0);
        @(negedge clk);
        chk("R2 nothing queued", fifo_not_empty, 0);
    endtask

    task automatic t_filter_off_and_per_write;
        wr(21'h000005, 32'hA5A5_12FF, 4'hF, 1'b1, 1'b0);
        @(negedge clk);
        chk("R3 unchanged sent", fifo_not_empty, 1);
        pop_chk("R3 msg", 21'h000005, 32'hA5A5_12FF, 1'b1);
        wr(21'h000007, 32'h0, 4'hF, 1'b0, 1'b1);
        wr(21'h000007, 32'h0, 4'hF, 1'b1, 1'b0);
        wr(21'h000007, 32'h0, 4'hF, 1'b0, 1'b1);
        pop_chk("R9 only unfiltered", 21'h000007, 32'h0, 1'b1);
        @(negedge clk);
        chk("R9 one message", fifo_not_empty, 0);
    endtask

    task automatic t_order;
        wr(21'h000001, 32'h11, 4'hF, 1'b0, 1'b1);
        wr(21'h000002, 32'h22, 4'hF, 1'b1, 1'b1);
        wr(21'h000003, 32'h33, 4'hF, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5 head held", tx_addr, 21'h000001);
        pop_chk("R5 first", 21'h000001, 32'h11, 1'b0);
        pop_chk("R5 second", 21'h000002, 32'h22, 1'b1);
        pop_chk("R5 third", 21'h000003, 32'h33, 1'b0);
        @(negedge clk);
        chk("R5 drained", fifo_not_empty, 0);
    endtask

    task automatic t_enable;
        tx_enable = 1'b0;
        wr(21'h000004, 32'h44, 4'hF, 1'b0, 1'b1);
        chk("R6 valid gated", tx_valid, 0);
        tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        tx_ready = 1'b0;
        chk("R6 kept", fifo_not_empty, 1);
        tx_enable = 1'b1;
        pop_chk("R6 after enable", 21'h000004, 32'h44, 1'b0);
        @(negedge clk);
        chk("R6 drained", fifo_not_empty, 0);
    endtask

    task automatic burst(input int n);
        @(negedge clk);
        hw_addr = 21'h000009; hw_data = 32'hDEAD_BEEF; hw_be = 4'hF;
        hw_irq = 1'b0; filt_en = 1'b0; hw_valid = 1'b1;
        repeat (n) @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic t_levels_and_stall;
        tx_enable = 1'b0;
        rd_addr = 8'd9;
        burst(DEPTH - DEPTH / 8 - 1);
        chk("R8 below mark", fifo_high, 0);
        chk("R8 not_empty", fifo_not_empty, 1);
        burst(1);
        chk("R8 at mark", fifo_high, 1);
        burst(DEPTH / 8 - 1);
        chk("R7 one short", fifo_full, 0);
        chk("R7 ready before full", hw_ready, 1);
        burst(1);
        chk("R7 full", fifo_full, 1);
        chk("R7 stall", hw_ready, 0);
        hw_addr = 21'h000009; hw_data = 32'h0000_1234; filt_en = 1'b1;
        hw_valid = 1'b1;
        @(negedge clk);
        chk("R7 still stalled", hw_ready, 0);
        chk("R7 mem untouched", rd_data, 32'hDEAD_BEEF);
        tx_enable = 1'b1;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R7 room after pop", fifo_full, 0);
        chk("R7 ready after pop", hw_ready, 1);
        @(negedge clk);
        hw_valid = 1'b0;
        chk("R7 accepted", rd_data, 32'h0000_1234);
        chk("R7 full again", fifo_full, 1);
        tx_ready = 1'b1;
        while (fifo_not_empty) @(negedge clk);
        tx_ready = 1'b0;
        chk("R8 empty after drain", fifo_high, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_change_merge();
        t_filter_equal();
        t_filter_off_and_per_write();
        t_order();
        t_enable();
        t_levels_and_stall();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule